// File: doc/BRIEF.md
# Directory Home Controller with Uncached DMA Access

This block is the home node for a set of cache lines shared by a few caching agents and one cacheless DMA agent. For every line it keeps a directory entry and the line's backing data. An entry holds a state (Uncached, Shared or Modified), a bit vector of the caches that hold a copy, and the id of the single owner when the line is Modified. Agents send requests on a request channel. The controller queues them and handles them strictly one at a time, so it is the only place where accesses to a line are ordered. When a request conflicts with copies held elsewhere, the controller sends one multicast snoop to exactly the caches involved. It counts their acknowledgements on a per-cache ack channel, and only when the count reaches zero does it update the entry and answer the requester.

The DMA agent uses two requests of its own. An uncached read returns the newest value of the line: if a cache holds the line Modified, that owner is made to supply the data. An uncached write removes every cached copy and puts the new data straight into the backing store. Neither request ever records the DMA agent as a sharer or as an owner.

Top module: `dir_home_ctrl`

## Requirements
- R1: Each directory entry is consistent. A Modified line has an empty sharer vector and one owner. A Shared line has at least one sharer. An Uncached line has no sharers. After reset every line is Uncached and its data is zero.
- R2: A read (op 0) to an Uncached or Shared line sends no snoop. It answers the requester with a shared grant (rsp op 0) carrying the stored data, and it adds the requester to the sharer vector.
- R3: An ownership request (op 1) to a Shared line sends one invalidate snoop (snoop op 0). The snoop goes to every listed sharer except the requester. The ownership grant (rsp op 1) is issued only after every one of those caches has acknowledged.
- R4: A read to a Modified line sends a downgrade snoop (snoop op 1) to the owner alone. The requester receives the owner's acknowledged data, and that data is also written into the store. Afterwards the owner and the requester are both sharers, so a later ownership request from a third cache invalidates exactly those two.
- R5: An ownership request to a line Modified in another cache sends a flush snoop (snoop op 2) to that owner. The owner's data is forwarded in the grant, and ownership moves to the requester.
- R6: A DMA uncached read (op 3, source id 4) returns the latest value on rsp op 2. If the line is Modified, the owner is downgraded with snoop op 1 and supplies the data. Otherwise no snoop is sent. The DMA agent is never recorded as a sharer.
- R7: A DMA write (op 4) invalidates every cached copy with snoop op 0 and stores the request data. It leaves the line Uncached and answers with rsp op 3. A following read returns the DMA data without any snoop.
- R8: A clean eviction (op 2) removes the sender from the sharer vector and answers with rsp op 3. When the vector becomes empty, the line returns to Uncached.
- R9: Requests are served in arrival order, one transaction at a time. A request that arrives while acknowledgements are outstanding waits in the queue. When the queue is full, req_ready is low.
- R10: Out of reset req_ready is high and neither snp_valid nor rsp_valid is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request queue can accept |
| req_src | input | 3 | Sender id: 0..3 caches, 4 DMA agent |
| req_op | input | 3 | 0 read, 1 ownership, 2 clean evict, 3 DMA read, 4 DMA write |
| req_line | input | 4 | Line index |
| req_data | input | 16 | Write data for DMA write |
| snp_valid | output | 1 | Snoop issued this cycle |
| snp_dest | output | 4 | One bit per target cache |
| snp_op | output | 2 | 0 invalidate, 1 downgrade with data, 2 flush with data |
| snp_line | output | 4 | Snooped line |
| ack_valid | input | 4 | One acknowledgement pulse per cache |
| ack_data | input | 16 | Data supplied by an acknowledging owner |
| rsp_valid | output | 1 | Response issued this cycle |
| rsp_dst | output | 3 | Receiver id |
| rsp_op | output | 2 | 0 shared grant, 1 ownership grant, 2 DMA data, 3 done |
| rsp_line | output | 4 | Line of the response |
| rsp_data | output | 16 | Line data (zero for done) |

## Verification
Two things can happen in the same clock while an ownership request waits: acknowledgements from several sharers, and the arrival of a new request. The bench gives two sharers the same acknowledgement delay, so the counter must drop by two in a single cycle. It also pushes a read for the same line right behind the ownership request, so that read enters the queue while the count is still non-zero. The ownership grant is accepted only if the bench's own tally of outstanding acknowledgements is zero when the grant appears. The queued read must then be answered after the grant, with a downgrade of the new owner, and not before.

// File: rtl/dir_pkg.sv
// Package: shared encodings for the directory home controller.
// Assumes: request, snoop and response codes are fixed by the channel contract.
package dir_pkg;
    typedef enum logic [1:0] {
        DIR_U = 2'd0,
        DIR_S = 2'd1,
        DIR_M = 2'd2
    } dir_state_e;

    typedef enum logic [2:0] {
        RQ_RD     = 3'd0,
        RQ_RFO    = 3'd1,
        RQ_EVICT  = 3'd2,
        RQ_DMA_RD = 3'd3,
        RQ_DMA_WR = 3'd4
    } req_op_e;

    typedef enum logic [1:0] {
        SN_INV   = 2'd0,
        SN_DOWN  = 2'd1,
        SN_FLUSH = 2'd2
    } snp_op_e;

    typedef enum logic [1:0] {
        RS_SHARED   = 2'd0,
        RS_OWNED    = 2'd1,
        RS_DMA_DATA = 2'd2,
        RS_DONE     = 2'd3
    } rsp_op_e;

    typedef enum logic [1:0] {
        E_IDLE   = 2'd0,
        E_DECIDE = 2'd1,
        E_WAIT   = 2'd2,
        E_FINISH = 2'd3
    } eng_e;
endpackage

// File: rtl/dir_req_queue.sv
// Module: in-order request queue in front of the directory engine.
// Assumes: DEPTH is a power of two; the consumer pops only when out_valid.
module dir_req_queue #(
    parameter int W     = 8,
    parameter int DEPTH = 4,
    parameter int PTR_W = $clog2(DEPTH)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    output logic         in_ready,
    input  logic [W-1:0] in_data,
    output logic         out_valid,
    output logic [W-1:0] out_data,
    input  logic         out_pop
);
    localparam int CNT_W = PTR_W + 1;

    logic [W-1:0]     slot [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] count;
    logic             push, pop;

    assign in_ready  = (count != CNT_W'(DEPTH));
    assign out_valid = (count != '0);
    assign out_data  = slot[rd_ptr];
    assign push      = in_valid && in_ready;
    assign pop       = out_pop && out_valid;

    // Storage write: no reset needed, contents qualified by count.
    always_ff @(posedge clk) begin
        if (push) slot[wr_ptr] <= in_data;
    end

    // Pointer and occupancy tracking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= wr_ptr + PTR_W'(1);
            if (pop)  rd_ptr <= rd_ptr + PTR_W'(1);
            case ({push, pop})
                2'b10:   count <= count + CNT_W'(1);
                2'b01:   count <= count - CNT_W'(1);
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/dir_ack_tracker.sv
// Module: records which caches still owe an acknowledgement and how many.
// Assumes: load happens only when nothing is pending; stray acks are ignored.
module dir_ack_tracker #(
    parameter int N  = 4,
    parameter int CW = $clog2(N + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [N-1:0]  load_mask,
    input  logic [N-1:0]  ack_valid,
    output logic [N-1:0]  pend_mask,
    output logic [CW-1:0] pend_cnt,
    output logic          ack_hit
);
    function automatic logic [CW-1:0] ones(input logic [N-1:0] v);
        logic [CW-1:0] s;
        s = '0;
        for (int i = 0; i < N; i++) s = s + CW'(v[i]);
        return s;
    endfunction

    logic [N-1:0] hit;
    assign hit     = ack_valid & pend_mask;
    assign ack_hit = (hit != '0);

    // Load on snoop issue, then retire each acknowledging cache once.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_mask <= '0;
            pend_cnt  <= '0;
        end else if (load) begin
            pend_mask <= load_mask;
            pend_cnt  <= ones(load_mask);
        end else begin
            pend_mask <= pend_mask & ~ack_valid;
            pend_cnt  <= pend_cnt - ones(hit);
        end
    end
endmodule

// File: rtl/dir_line_store.sv
// Module: per-line directory entries and backing data with one read and one write port.
// Assumes: read is combinational; directory and data writes land at the clock edge.
module dir_line_store
    import dir_pkg::*;
#(
    parameter int LINES  = 16,
    parameter int N      = 4,
    parameter int OWN_W  = 2,
    parameter int DW     = 16,
    parameter int LINE_W = $clog2(LINES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LINE_W-1:0] rd_line,
    output dir_state_e        rd_state,
    output logic [N-1:0]      rd_sharers,
    output logic [OWN_W-1:0]  rd_owner,
    output logic [DW-1:0]     rd_data,
    input  logic              dir_we,
    input  logic [LINE_W-1:0] wr_line,
    input  dir_state_e        wr_state,
    input  logic [N-1:0]      wr_sharers,
    input  logic [OWN_W-1:0]  wr_owner,
    input  logic              mem_we,
    input  logic [DW-1:0]     mem_wdata
);
    dir_state_e       st  [LINES];
    logic [N-1:0]     shr [LINES];
    logic [OWN_W-1:0] own [LINES];
    logic [DW-1:0]    dat [LINES];

    assign rd_state   = st[rd_line];
    assign rd_sharers = shr[rd_line];
    assign rd_owner   = own[rd_line];
    assign rd_data    = dat[rd_line];

    // Directory entry update; all lines Uncached after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < LINES; i++) begin
                st[i]  <= DIR_U;
                shr[i] <= '0;
                own[i] <= '0;
            end
        end else if (dir_we) begin
            st[wr_line]  <= wr_state;
            shr[wr_line] <= wr_sharers;
            own[wr_line] <= wr_owner;
        end
    end

    // Backing data update; all lines zero after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < LINES; i++) dat[i] <= '0;
        end else if (mem_we) begin
            dat[wr_line] <= mem_wdata;
        end
    end
endmodule

// File: rtl/dir_home_ctrl.sv
// Module: directory home controller serving caching agents and one cacheless DMA agent.
// Assumes: ids 0..NUM_CACHES-1 are caches and id NUM_CACHES is the DMA agent;
// each snooped cache acknowledges exactly once and an owner returns data with its ack.
module dir_home_ctrl
    import dir_pkg::*;
#(
    parameter int NUM_CACHES  = 4,
    parameter int NUM_LINES   = 16,
    parameter int DATA_W      = 16,
    parameter int QUEUE_DEPTH = 4,
    parameter int SRC_W       = $clog2(NUM_CACHES + 1),
    parameter int LINE_W      = $clog2(NUM_LINES)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    output logic                  req_ready,
    input  logic [SRC_W-1:0]      req_src,
    input  logic [2:0]            req_op,
    input  logic [LINE_W-1:0]     req_line,
    input  logic [DATA_W-1:0]     req_data,
    output logic                  snp_valid,
    output logic [NUM_CACHES-1:0] snp_dest,
    output logic [1:0]            snp_op,
    output logic [LINE_W-1:0]     snp_line,
    input  logic [NUM_CACHES-1:0] ack_valid,
    input  logic [DATA_W-1:0]     ack_data,
    output logic                  rsp_valid,
    output logic [SRC_W-1:0]      rsp_dst,
    output logic [1:0]            rsp_op,
    output logic [LINE_W-1:0]     rsp_line,
    output logic [DATA_W-1:0]     rsp_data
);
    localparam int OWN_W = (NUM_CACHES > 1) ? $clog2(NUM_CACHES) : 1;
    localparam int CNT_W = $clog2(NUM_CACHES + 1);
    localparam int Q_W   = SRC_W + 3 + LINE_W + DATA_W;
    localparam int N     = NUM_CACHES;

    // Request queue
    logic           q_valid, q_pop;
    logic [Q_W-1:0] q_data;

    dir_req_queue #(.W(Q_W), .DEPTH(QUEUE_DEPTH)) u_queue (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (req_valid),
        .in_ready (req_ready),
        .in_data  ({req_src, req_op, req_line, req_data}),
        .out_valid(q_valid),
        .out_data (q_data),
        .out_pop  (q_pop)
    );

    // Current transaction
    eng_e              eng;
    logic [SRC_W-1:0]  cur_src;
    req_op_e           cur_op;
    logic [LINE_W-1:0] cur_line;
    logic [DATA_W-1:0] cur_data;
    snp_op_e           cur_snp;
    logic              snooped;
    logic [DATA_W-1:0] fetched;

    assign q_pop = (eng == E_IDLE) && q_valid;

    // Directory entry of the current line
    dir_state_e        e_state;
    logic [N-1:0]      e_sharers;
    logic [OWN_W-1:0]  e_owner;
    logic [DATA_W-1:0] e_data;

    // Outcome of the transaction
    dir_state_e        fin_state;
    logic [N-1:0]      fin_sharers;
    logic [OWN_W-1:0]  fin_owner;
    logic              fin_mem_we;
    logic [DATA_W-1:0] fin_mem_data;
    rsp_op_e           fin_rsp_op;
    logic [DATA_W-1:0] fin_rsp_data;

    dir_line_store #(
        .LINES(NUM_LINES), .N(N), .OWN_W(OWN_W), .DW(DATA_W), .LINE_W(LINE_W)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_line   (cur_line),
        .rd_state  (e_state),
        .rd_sharers(e_sharers),
        .rd_owner  (e_owner),
        .rd_data   (e_data),
        .dir_we    (eng == E_FINISH),
        .wr_line   (cur_line),
        .wr_state  (fin_state),
        .wr_sharers(fin_sharers),
        .wr_owner  (fin_owner),
        .mem_we    ((eng == E_FINISH) && fin_mem_we),
        .mem_wdata (fin_mem_data)
    );

    // Acknowledgement counting
    logic [N-1:0]     dec_mask;
    snp_op_e          dec_snp;
    logic [N-1:0]     pend_mask;
    logic [CNT_W-1:0] pend_cnt;
    logic             ack_hit;
    logic             load_acks;

    assign load_acks = (eng == E_DECIDE) && (dec_mask != '0);

    dir_ack_tracker #(.N(N), .CW(CNT_W)) u_acks (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load_acks),
        .load_mask(dec_mask),
        .ack_valid(ack_valid),
        .pend_mask(pend_mask),
        .pend_cnt (pend_cnt),
        .ack_hit  (ack_hit)
    );

    // Requester and owner as cache bit vectors
    logic         is_cache;
    logic [N-1:0] req_bit;
    logic [N-1:0] owner_bit;
    logic         owner_is_req;

    assign is_cache     = (cur_src < SRC_W'(N));
    assign req_bit      = is_cache ? (N'(1) << cur_src) : '0;
    assign owner_bit    = N'(1) << e_owner;
    assign owner_is_req = is_cache && (SRC_W'(e_owner) == cur_src);

    // Decide which caches must be snooped, and how, before the request can complete.
    always_comb begin
        dec_mask = '0;
        dec_snp  = SN_INV;
        case (cur_op)
            RQ_RD: begin
                if (e_state == DIR_M && !owner_is_req) begin
                    dec_mask = owner_bit;
                    dec_snp  = SN_DOWN;
                end
            end
            RQ_RFO: begin
                if (e_state == DIR_S) begin
                    dec_mask = e_sharers & ~req_bit;
                    dec_snp  = SN_INV;
                end else if (e_state == DIR_M && !owner_is_req) begin
                    dec_mask = owner_bit;
                    dec_snp  = SN_FLUSH;
                end
            end
            RQ_DMA_RD: begin
                if (e_state == DIR_M) begin
                    dec_mask = owner_bit;
                    dec_snp  = SN_DOWN;
                end
            end
            RQ_DMA_WR: begin
                if (e_state == DIR_S) dec_mask = e_sharers;
                else if (e_state == DIR_M) dec_mask = owner_bit;
                dec_snp = SN_INV;
            end
            default: begin
                dec_mask = '0;
                dec_snp  = SN_INV;
            end
        endcase
    end

    // Compute the new entry, store write and response once all acks are in.
    always_comb begin
        logic [DATA_W-1:0] latest;
        latest       = (snooped && cur_snp != SN_INV) ? fetched : e_data;
        fin_state    = e_state;
        fin_sharers  = e_sharers;
        fin_owner    = e_owner;
        fin_mem_we   = snooped && (cur_snp != SN_INV);
        fin_mem_data = fetched;
        fin_rsp_op   = RS_DONE;
        fin_rsp_data = '0;
        case (cur_op)
            RQ_RD: begin
                fin_state    = DIR_S;
                fin_sharers  = ((e_state == DIR_M) ? owner_bit : e_sharers) | req_bit;
                fin_rsp_op   = RS_SHARED;
                fin_rsp_data = latest;
            end
            RQ_RFO: begin
                fin_state    = DIR_M;
                fin_sharers  = '0;
                fin_owner    = cur_src[OWN_W-1:0];
                fin_rsp_op   = RS_OWNED;
                fin_rsp_data = latest;
            end
            RQ_EVICT: begin
                if (e_state == DIR_S) begin
                    fin_sharers = e_sharers & ~req_bit;
                    if ((e_sharers & ~req_bit) == '0) fin_state = DIR_U;
                end else if (e_state == DIR_M && owner_is_req) begin
                    fin_state   = DIR_U;
                    fin_sharers = '0;
                end
            end
            RQ_DMA_RD: begin
                if (e_state == DIR_M) begin
                    fin_state   = DIR_S;
                    fin_sharers = owner_bit;
                end
                fin_rsp_op   = RS_DMA_DATA;
                fin_rsp_data = latest;
            end
            RQ_DMA_WR: begin
                fin_state    = DIR_U;
                fin_sharers  = '0;
                fin_mem_we   = 1'b1;
                fin_mem_data = cur_data;
            end
            default: begin
                fin_rsp_op = RS_DONE;
            end
        endcase
    end

    // Transaction engine: pop, decide, wait for acks, finish.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            eng      <= E_IDLE;
            cur_src  <= '0;
            cur_op   <= RQ_RD;
            cur_line <= '0;
            cur_data <= '0;
            cur_snp  <= SN_INV;
            snooped  <= 1'b0;
            fetched  <= '0;
        end else begin
            case (eng)
                E_IDLE: begin
                    if (q_valid) begin
                        {cur_src, cur_op, cur_line, cur_data} <= q_data;
                        eng <= E_DECIDE;
                    end
                end
                E_DECIDE: begin
                    cur_snp <= dec_snp;
                    snooped <= (dec_mask != '0);
                    eng     <= (dec_mask != '0) ? E_WAIT : E_FINISH;
                end
                E_WAIT: begin
                    if (ack_hit) fetched <= ack_data;
                    if (pend_cnt == '0) eng <= E_FINISH;
                end
                default: begin
                    eng <= E_IDLE;
                end
            endcase
        end
    end

    // Snoop channel: one multicast message per transaction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            snp_valid <= 1'b0;
            snp_dest  <= '0;
            snp_op    <= '0;
            snp_line  <= '0;
        end else begin
            snp_valid <= load_acks;
            if (load_acks) begin
                snp_dest <= dec_mask;
                snp_op   <= dec_snp;
                snp_line <= cur_line;
            end
        end
    end

    // Response channel: one message when the transaction completes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_dst   <= '0;
            rsp_op    <= '0;
            rsp_line  <= '0;
            rsp_data  <= '0;
        end else begin
            rsp_valid <= (eng == E_FINISH);
            if (eng == E_FINISH) begin
                rsp_dst  <= cur_src;
                rsp_op   <= fin_rsp_op;
                rsp_line <= cur_line;
                rsp_data <= fin_rsp_data;
            end
        end
    end
endmodule

// File: rtl/dir_home_ctrl_chk.sv
// Module: protocol checker bound to the directory home controller.
// Assumes: it observes the controller's channels, ack counter and current entry.
module dir_home_ctrl_chk #(
    parameter int N     = 4,
    parameter int SRC_W = 3,
    parameter int CW    = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             snp_valid,
    input logic [N-1:0]     snp_dest,
    input logic [1:0]       snp_op,
    input logic             rsp_valid,
    input logic [1:0]       rsp_op,
    input logic [CW-1:0]    pend_cnt,
    input logic [SRC_W-1:0] cur_src,
    input logic [1:0]       e_state,
    input logic [N-1:0]     e_sharers
);
    // R1: a Modified entry lists no sharers
    a_r1_modified_no_sharers: assert property (@(posedge clk) disable iff (!rst_n)
        (e_state == 2'd2) |-> (e_sharers == '0));

    // R1: a Shared entry lists at least one sharer
    a_r1_shared_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
        (e_state == 2'd1) |-> (e_sharers != '0));

    // R1: an Uncached entry lists nobody
    a_r1_uncached_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (e_state == 2'd0) |-> (e_sharers == '0));

    // R3: ownership grant only when no acknowledgement is outstanding
    a_r3_grant_after_acks: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_op == 2'd1) |-> (pend_cnt == '0));

    // R3: the requester is never among the snooped caches
    a_r3_requester_excluded: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_valid && cur_src < SRC_W'(N)) |-> ((snp_dest & (N'(1) << cur_src)) == '0));

    // R4: data-fetching snoops target exactly one owner
    a_r4_fetch_single_owner: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_valid && snp_op != 2'd0) |-> $onehot(snp_dest));

    // R9: at most one snoop per transaction, never back to back
    a_r9_single_snoop: assert property (@(posedge clk) disable iff (!rst_n)
        snp_valid |=> !snp_valid);

    // R9: one response per transaction, never back to back
    a_r9_single_response: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);
endmodule

bind dir_home_ctrl dir_home_ctrl_chk #(.N(NUM_CACHES), .SRC_W(SRC_W), .CW(CNT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .snp_valid(snp_valid),
    .snp_dest (snp_dest),
    .snp_op   (snp_op),
    .rsp_valid(rsp_valid),
    .rsp_op   (rsp_op),
    .pend_cnt (pend_cnt),
    .cur_src  (cur_src),
    .e_state  (e_state),
    .e_sharers(e_sharers)
);

// File: tb/dir_home_ctrl_bench.sv
// Bench: scoreboard of expected snoops and responses, with a cache acknowledgement model.
module dir_home_ctrl_bench;
    localparam int NC = 4;
    localparam int NL = 16;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [2:0]    req_src = '0;
    logic [2:0]    req_op = '0;
    logic [3:0]    req_line = '0;
    logic [DW-1:0] req_data = '0;
    logic          snp_valid;
    logic [NC-1:0] snp_dest;
    logic [1:0]    snp_op;
    logic [3:0]    snp_line;
    logic [NC-1:0] ack_valid = '0;
    logic [DW-1:0] ack_data = '0;
    logic          rsp_valid;
    logic [2:0]    rsp_dst;
    logic [1:0]    rsp_op;
    logic [3:0]    rsp_line;
    logic [DW-1:0] rsp_data;

    always #4 clk = ~clk;

    dir_home_ctrl u_dir_home_ctrl (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_src(req_src),
        .req_op(req_op), .req_line(req_line), .req_data(req_data),
        .snp_valid(snp_valid), .snp_dest(snp_dest), .snp_op(snp_op), .snp_line(snp_line),
        .ack_valid(ack_valid), .ack_data(ack_data),
        .rsp_valid(rsp_valid), .rsp_dst(rsp_dst), .rsp_op(rsp_op),
        .rsp_line(rsp_line), .rsp_data(rsp_data)
    );

    typedef struct {
        logic [2:0]    dst;
        logic [1:0]    op;
        logic [3:0]    line;
        logic [DW-1:0] data;
        string         tag;
    } rsp_t;

    typedef struct {
        logic [NC-1:0] mask;
        logic [1:0]    op;
        logic [3:0]    line;
        string         tag;
    } snp_t;

    rsp_t rsp_q[$];
    snp_t snp_q[$];

    int checks = 0;
    int errors = 0;
    int pending_acks = 0;
    int cycles = 0;
    bit done = 1'b0;
    bit saw_full = 1'b0;

    logic [DW-1:0] cache_val [NC][NL];
    int            dly [NC];
    int            timer [NC];

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic exp_rsp(input logic [2:0] d, input logic [1:0] o, input logic [3:0] l,
                           input logic [DW-1:0] v, input string tag);
        rsp_t e;
        e.dst = d; e.op = o; e.line = l; e.data = v; e.tag = tag;
        rsp_q.push_back(e);
    endtask

    task automatic exp_snp(input logic [NC-1:0] m, input logic [1:0] o, input logic [3:0] l,
                           input string tag);
        snp_t e;
        e.mask = m; e.op = o; e.line = l; e.tag = tag;
        snp_q.push_back(e);
    endtask

    task automatic send(input logic [2:0] s, input logic [2:0] o, input logic [3:0] l,
                        input logic [DW-1:0] v);
        @(negedge clk);
        req_valid = 1'b0;
        while (!req_ready) @(negedge clk);
        req_src = s; req_op = o; req_line = l; req_data = v;
        req_valid = 1'b1;
    endtask

    task automatic idle();
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic drain();
        int t;
        idle();
        t = 0;
        while ((rsp_q.size() != 0 || snp_q.size() != 0 || pending_acks != 0) && t < 2000) begin
            @(negedge clk);
            t++;
        end
        repeat (4) @(negedge clk);
    endtask

    // Cache model: acknowledge each snoop after a per-cache delay, owners return data.
    always @(posedge clk) begin
        #2;
        ack_valid = '0;
        for (int c = 0; c < NC; c++) begin
            if (timer[c] > 0) begin
                timer[c] = timer[c] - 1;
                if (timer[c] == 0) begin
                    ack_valid[c] = 1'b1;
                    ack_data = cache_val[c][snp_line];
                    pending_acks--;
                end
            end
            if (rst_n && snp_valid && snp_dest[c]) begin
                timer[c] = dly[c];
                pending_acks++;
            end
        end
    end

    // Monitor: compare observed snoops and responses with the scoreboard.
    always @(negedge clk) begin
        if (rst_n && !req_ready) saw_full = 1'b1;
        if (rst_n && snp_valid) begin
            if (snp_q.size() == 0) begin
                chk(1'b0, "R2", "unexpected snoop", {snp_dest, snp_op, snp_line}, 32'h0);
            end else begin
                snp_t e;
                e = snp_q.pop_front();
                chk(snp_dest == e.mask && snp_op == e.op && snp_line == e.line, e.tag,
                    "snoop dest/op/line", {snp_dest, snp_op, snp_line}, {e.mask, e.op, e.line});
            end
        end
        if (rst_n && rsp_valid) begin
            if (rsp_q.size() == 0) begin
                chk(1'b0, "R9", "unexpected response", {rsp_dst, rsp_op, rsp_line, rsp_data}, 32'h0);
            end else begin
                rsp_t e;
                e = rsp_q.pop_front();
                chk(rsp_dst == e.dst && rsp_op == e.op && rsp_line == e.line && rsp_data == e.data,
                    e.tag, "response dst/op/line/data",
                    {3'b0, rsp_dst, rsp_op, rsp_line, rsp_data}, {3'b0, e.dst, e.op, e.line, e.data});
                if (rsp_op == 2'd1 || rsp_op == 2'd3)
                    chk(pending_acks == 0, "R3", "grant with acks outstanding", pending_acks, 0);
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as a failed check.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 100000);
            finish_run();
        end
    end

    initial begin
        for (int c = 0; c < NC; c++) begin
            dly[c] = 3;
            timer[c] = 0;
            for (int l = 0; l < NL; l++) cache_val[c][l] = '0;
        end
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: state out of reset
        chk(req_ready == 1'b1, "R10", "req_ready after reset", req_ready, 1);
        chk(snp_valid == 1'b0, "R10", "snp_valid after reset", snp_valid, 0);
        chk(rsp_valid == 1'b0, "R10", "rsp_valid after reset", rsp_valid, 0);

        // R2: three readers on an Uncached line, no snoops, zero data (R1 reset value)
        exp_rsp(0, 0, 1, 16'h0, "R2");
        exp_rsp(1, 0, 1, 16'h0, "R2");
        exp_rsp(2, 0, 1, 16'h0, "R1");
        send(0, 0, 1, 0);
        send(1, 0, 1, 0);
        send(2, 0, 1, 0);
        drain();

        // R3 with R9: sharers 1 and 2 ack in the same cycle; a read queues behind.
        cache_val[0][1] = 16'hA5A5;
        exp_snp(4'b0110, 0, 1, "R3");
        exp_rsp(0, 1, 1, 16'h0, "R3");
        exp_snp(4'b0001, 1, 1, "R9");
        exp_rsp(3, 0, 1, 16'hA5A5, "R9");
        send(0, 1, 1, 0);
        send(3, 0, 1, 0);
        drain();

        // R4: both the old owner and the reader are now sharers; staggered acks.
        dly[0] = 2;
        dly[3] = 6;
        exp_snp(4'b1001, 0, 1, "R4");
        exp_rsp(1, 1, 1, 16'hA5A5, "R4");
        send(1, 1, 1, 0);
        drain();

        // R5: ownership moves from cache 1 to cache 2 with a flush.
        cache_val[1][1] = 16'h1111;
        exp_snp(4'b0010, 2, 1, "R5");
        exp_rsp(2, 1, 1, 16'h1111, "R5");
        send(2, 1, 1, 0);
        drain();

        // R6: DMA read fetches from owner 2; DMA is not left as a sharer.
        cache_val[2][1] = 16'h2222;
        exp_snp(4'b0100, 1, 1, "R6");
        exp_rsp(4, 2, 1, 16'h2222, "R6");
        exp_rsp(2, 3, 1, 16'h0, "R8");
        exp_rsp(3, 1, 1, 16'h2222, "R6");
        send(4, 3, 1, 0);
        send(2, 2, 1, 0);
        send(3, 1, 1, 0);
        drain();

        // R6: DMA read of an Uncached line sends no snoop.
        exp_rsp(4, 2, 5, 16'h0, "R6");
        send(4, 3, 5, 0);
        drain();

        // R7: DMA write to a Shared line, then a plain read sees the new data.
        exp_rsp(0, 0, 2, 16'h0, "R2");
        exp_rsp(1, 0, 2, 16'h0, "R2");
        exp_snp(4'b0011, 0, 2, "R7");
        exp_rsp(4, 3, 2, 16'h0, "R7");
        exp_rsp(2, 0, 2, 16'hBEEF, "R7");
        send(0, 0, 2, 0);
        send(1, 0, 2, 0);
        send(4, 4, 2, 16'hBEEF);
        send(2, 0, 2, 0);
        drain();

        // R7: DMA write to a Modified line, then DMA read sees it with no snoop.
        exp_snp(4'b1000, 0, 1, "R7");
        exp_rsp(4, 3, 1, 16'h0, "R7");
        exp_rsp(4, 2, 1, 16'h0C0C, "R7");
        send(4, 4, 1, 16'h0C0C);
        send(4, 3, 1, 0);
        drain();

        // R8: eviction removes one sharer; ownership request then invalidates only the other.
        exp_rsp(0, 0, 3, 16'h0, "R8");
        exp_rsp(1, 0, 3, 16'h0, "R8");
        exp_rsp(0, 3, 3, 16'h0, "R8");
        exp_snp(4'b0010, 0, 3, "R8");
        exp_rsp(2, 1, 3, 16'h0, "R8");
        send(0, 0, 3, 0);
        send(1, 0, 3, 0);
        send(0, 2, 3, 0);
        send(2, 1, 3, 0);
        drain();

        // R9: burst of reads fills the queue and is answered in arrival order.
        for (int i = 0; i < 12; i++) exp_rsp(3'(i % NC), 0, 4, 16'h0, "R9");
        for (int i = 0; i < 12; i++) send(3'(i % NC), 0, 4, 0);
        drain();
        chk(saw_full, "R9", "req_ready low on full queue", saw_full, 1);

        chk(rsp_q.size() == 0, "R9", "responses outstanding at end", rsp_q.size(), 0);
        chk(snp_q.size() == 0, "R3", "snoops outstanding at end", snp_q.size(), 0);
        finish_run();
    end
endmodule